// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws into a linear, byte-addressed framebuffer. It accepts one command at a time on a valid/ready handshake. A command is either a solid fill of a rectangle with a 32-bit colour or a copy of a rectangle from one place to another. It then walks the rectangle one byte per cycle on a simple memory port. The row pitch in bytes and the pixel size (1 to 4 bytes) are configuration inputs, and both are captured when a command is accepted.

Every finished command records its destination rectangle in a circular queue of damaged regions. A later flush request replays the queue, oldest entry first, through a clamp that trims each rectangle to the visible surface size. When the invalidate input is raised with the flush, the pending entries are dropped instead, because a full redraw makes them pointless.

Top module: `rect_fill_copy_engine`

## Requirements
- R1: Pixel (x, y) starts at byte address bpp*x + pitch*y, where bpp is `cfg_bpp` (1 to 4) and pitch is `cfg_pitch`, both captured when the command is accepted.
- R2: A fill (`cmd_op` = 0) writes the colour bytes least significant first, restarting every bpp bytes, across each row of the rectangle. Every row ends up identical to the first. The fill makes h*w*bpp writes and (h-1)*w*bpp reads.
- R3: A copy (`cmd_op` = 1) whose destination y is greater than its source y handles rows from the last row upward. Any other copy handles rows from the first row downward. The result equals a copy through a temporary buffer, even when source and destination overlap. It makes h*w*bpp reads and h*w*bpp writes.
- R4: Each copied row behaves as an overlap-safe move of bpp*w bytes, so horizontal shifts within the same rows come out correct in both directions.
- R5: A command whose width or height is zero or negative makes no memory access, leaves memory unchanged, and still enqueues its rectangle.
- R6: `cmd_ready` is high only when the engine is idle. It is low in the cycle after an accept and for as long as the operation runs. Each cycle carries at most one byte access, and read data returns in the cycle after the read.
- R7: Each finished command pushes (x, y, w, h) of its destination into a 512-entry ring whose indices wrap modulo 512. Once more than 512 entries are pushed without a drain, only the entries past the last multiple of 512 remain visible.
- R8: A flush with `invalidate` high discards every pending entry by setting the read index equal to the write index. No rectangle is output, and a later plain flush outputs nothing.
- R9: A flush with `invalidate` low drains all pending entries, oldest first, one per cycle. The first `rect_valid` appears two clock edges after the edge that samples the flush.
- R10: An output rectangle is clamped on x and w in this order: a negative x is added to w and x becomes 0; a negative w becomes 0; if x + w exceeds `surf_w`, x is limited to `surf_w` and w becomes `surf_w` - x.
- R11: The same clamp rules apply to y and h against `surf_h`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pitch | input | PITCH_W | Bytes per framebuffer row |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4 |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_op | input | 1 | 0 fill, 1 copy |
| cmd_color | input | 32 | Fill colour |
| cmd_sx | input | COORD_W | Copy source x (signed) |
| cmd_sy | input | COORD_W | Copy source y (signed) |
| cmd_dx | input | COORD_W | Destination x (signed) |
| cmd_dy | input | COORD_W | Destination y (signed) |
| cmd_w | input | COORD_W | Width in pixels (signed) |
| cmd_h | input | COORD_W | Height in rows (signed) |
| mem_addr | output | ADDR_W | Byte address |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| surf_w | input | COORD_W | Surface width for clamping |
| surf_h | input | COORD_W | Surface height for clamping |
| flush_req | input | 1 | Start a drain or discard of the queue |
| invalidate | input | 1 | With `flush_req`: discard instead of drain |
| rect_valid | output | 1 | Clamped rectangle present |
| rect_x | output | COORD_W | Clamped x |
| rect_y | output | COORD_W | Clamped y |
| rect_w | output | COORD_W | Clamped width |
| rect_h | output | COORD_W | Clamped height |

## Verification
A command is taken on the clock edge where valid meets ready. `cmd_ready` must read low at the next falling edge. The bench then waits for it to rise again, and only then compares the whole framebuffer model and the byte-access counts with values computed from the requirements. The clamped rectangles are due two edges after the edge that samples a flush. The bench checks `rect_valid` at exactly that falling edge, collects the following beats for a fixed window, and then compares them in order with its own clamp of the rectangles it issued.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam logic OP_FILL = 1'b0;
  localparam logic OP_COPY = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_PAT,
    ST_RD,
    ST_WR,
    ST_NEXT,
    ST_PUSH
  } eng_st_t;
endpackage

// File: rtl/rfe_engine.sv
module rfe_engine #(
  parameter int ADDR_W  = 20,
  parameter int COORD_W = 12,
  parameter int PITCH_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PITCH_W-1:0]        cfg_pitch,
  input  logic [2:0]                cfg_bpp,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic                      cmd_op,
  input  logic [31:0]               cmd_color,
  input  logic signed [COORD_W-1:0] cmd_sx,
  input  logic signed [COORD_W-1:0] cmd_sy,
  input  logic signed [COORD_W-1:0] cmd_dx,
  input  logic signed [COORD_W-1:0] cmd_dy,
  input  logic signed [COORD_W-1:0] cmd_w,
  input  logic signed [COORD_W-1:0] cmd_h,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_we,
  output logic                      mem_re,
  output logic [7:0]                mem_wdata,
  input  logic [7:0]                mem_rdata,
  output logic                      push,
  output logic signed [COORD_W-1:0] push_x,
  output logic signed [COORD_W-1:0] push_y,
  output logic signed [COORD_W-1:0] push_w,
  output logic signed [COORD_W-1:0] push_h
);
  import rfe_pkg::*;

  localparam int NB_W = COORD_W + 3;

  eng_st_t                   state_q;
  logic                      op_q;
  logic [31:0]               color_q;
  logic signed [COORD_W-1:0] sx_q, sy_q, dx_q, dy_q, w_q, h_q;
  logic [COORD_W-1:0]        hm1_q, rc_q;
  logic [PITCH_W-1:0]        pitch_q;
  logic [2:0]                bpp_q;
  logic [NB_W-1:0]           nb_q, k_q;
  logic [1:0]                ph_q;
  logic [ADDR_W-1:0]         src_q, dst_q;
  logic                      back_q;

  function automatic logic [ADDR_W-1:0] pix_addr(input logic [COORD_W-1:0] x,
                                                 input logic [COORD_W-1:0] y,
                                                 input logic [2:0] bpp,
                                                 input logic [PITCH_W-1:0] pitch);
    return ADDR_W'(bpp) * ADDR_W'(x) + ADDR_W'(pitch) * ADDR_W'(y);
  endfunction

  logic               bottom_up;
  logic [COORD_W-1:0] ri;
  logic [ADDR_W-1:0]  row_dst, row_src;
  logic [NB_W-1:0]    off;
  logic               last_byte;

  always_comb begin
    bottom_up = (op_q == OP_COPY) && (dy_q > sy_q);
    ri        = bottom_up ? (hm1_q - rc_q) : rc_q;
    row_dst   = pix_addr($unsigned(dx_q), $unsigned(dy_q) + ri, bpp_q, pitch_q);
    if (op_q == OP_FILL)
      row_src = pix_addr($unsigned(dx_q), $unsigned(dy_q), bpp_q, pitch_q);
    else
      row_src = pix_addr($unsigned(sx_q), $unsigned(sy_q) + ri, bpp_q, pitch_q);
    off       = back_q ? (nb_q - NB_W'(1) - k_q) : k_q;
    last_byte = (k_q == nb_q - NB_W'(1));
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign mem_re    = (state_q == ST_RD);
  assign mem_we    = (state_q == ST_WR) || (state_q == ST_PAT);
  assign mem_addr  = (state_q == ST_RD) ? (src_q + ADDR_W'(off)) : (dst_q + ADDR_W'(off));
  assign mem_wdata = (state_q == ST_PAT) ? color_q[{ph_q, 3'b000} +: 8] : mem_rdata;
  assign push      = (state_q == ST_PUSH);
  assign push_x    = dx_q;
  assign push_y    = dy_q;
  assign push_w    = w_q;
  assign push_h    = h_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_FILL;
      color_q <= '0;
      sx_q    <= '0;
      sy_q    <= '0;
      dx_q    <= '0;
      dy_q    <= '0;
      w_q     <= '0;
      h_q     <= '0;
      hm1_q   <= '0;
      rc_q    <= '0;
      pitch_q <= '0;
      bpp_q   <= 3'd1;
      nb_q    <= '0;
      k_q     <= '0;
      ph_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      back_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          color_q <= cmd_color;
          sx_q    <= cmd_sx;
          sy_q    <= cmd_sy;
          dx_q    <= cmd_dx;
          dy_q    <= cmd_dy;
          w_q     <= cmd_w;
          h_q     <= cmd_h;
          hm1_q   <= $unsigned(cmd_h) - COORD_W'(1);
          rc_q    <= '0;
          pitch_q <= cfg_pitch;
          bpp_q   <= cfg_bpp;
          nb_q    <= NB_W'(cfg_bpp) * NB_W'($unsigned(cmd_w));
          state_q <= (cmd_w <= 0 || cmd_h <= 0) ? ST_PUSH : ST_ROW;
        end
        ST_ROW: begin
          dst_q <= row_dst;
          src_q <= row_src;
          k_q   <= '0;
          ph_q  <= '0;
          if (op_q == OP_FILL && rc_q == '0) begin
            back_q  <= 1'b0;
            state_q <= ST_PAT;
          end else begin
            back_q  <= (row_dst > row_src);
            state_q <= ST_RD;
          end
        end
        ST_PAT: begin
          k_q  <= k_q + NB_W'(1);
          ph_q <= ({1'b0, ph_q} == bpp_q - 3'd1) ? 2'd0 : ph_q + 2'd1;
          if (last_byte) state_q <= ST_NEXT;
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          k_q     <= k_q + NB_W'(1);
          state_q <= last_byte ? ST_NEXT : ST_RD;
        end
        ST_NEXT: begin
          rc_q    <= rc_q + COORD_W'(1);
          state_q <= (rc_q == hm1_q) ? ST_PUSH : ST_ROW;
        end
        ST_PUSH: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: memory traffic only while the command port is closed
  a_r6_no_access_when_ready: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> !cmd_ready);
  // R6: one byte lane per cycle
  a_r6_single_lane: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
  // R6 / R4: every read is consumed by a write in the next cycle
  a_r6_read_then_write: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (mem_we && !mem_re));
  // R6: an accepted command closes the port on the next cycle
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R7: a push finishes the command
  a_r7_push_then_idle: assert property (@(posedge clk) disable iff (rst)
    push |=> cmd_ready);
endmodule

// File: rtl/rfe_axis_clamp.sv
module rfe_axis_clamp #(
  parameter int COORD_W = 12
) (
  input  logic signed [COORD_W-1:0] pos_i,
  input  logic signed [COORD_W-1:0] len_i,
  input  logic [COORD_W-1:0]        lim_i,
  output logic signed [COORD_W-1:0] pos_o,
  output logic signed [COORD_W-1:0] len_o
);
  localparam int CW2 = COORD_W + 2;

  logic signed [CW2-1:0] p, l, lm;

  always_comb begin
    p  = CW2'(pos_i);
    l  = CW2'(len_i);
    lm = $signed({2'b00, lim_i});
    if (p < 0) begin
      l = l + p;
      p = '0;
    end
    if (l < 0) l = '0;
    if (p + l > lm) begin
      if (p > lm) p = lm;
      l = lm - p;
    end
    pos_o = COORD_W'(p);
    len_o = COORD_W'(l);
  end
endmodule

// File: rtl/rfe_dirty_ring.sv
module rfe_dirty_ring #(
  parameter int COORD_W = 12,
  parameter int DQ_AW   = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic signed [COORD_W-1:0] push_x,
  input  logic signed [COORD_W-1:0] push_y,
  input  logic signed [COORD_W-1:0] push_w,
  input  logic signed [COORD_W-1:0] push_h,
  input  logic                      flush_req,
  input  logic                      invalidate,
  input  logic [COORD_W-1:0]        surf_w,
  input  logic [COORD_W-1:0]        surf_h,
  output logic                      rect_valid,
  output logic signed [COORD_W-1:0] rect_x,
  output logic signed [COORD_W-1:0] rect_y,
  output logic signed [COORD_W-1:0] rect_w,
  output logic signed [COORD_W-1:0] rect_h
);
  localparam int DEPTH = 1 << DQ_AW;
  localparam int ENT_W = 4 * COORD_W;

  logic [ENT_W-1:0] ram [0:DEPTH-1];
  logic [ENT_W-1:0] rd_data;
  logic [DQ_AW-1:0] wr_q, rd_q;
  logic             drain_q, s1_v, pop, wipe;

  assign wipe = flush_req && invalidate;
  assign pop  = drain_q && (rd_q != wr_q) && !wipe;

  always_ff @(posedge clk) begin
    if (push) ram[wr_q] <= {push_x, push_y, push_w, push_h};
    if (pop)  rd_data   <= ram[rd_q];
  end

  logic signed [COORD_W-1:0] pos_in  [2];
  logic signed [COORD_W-1:0] len_in  [2];
  logic [COORD_W-1:0]        lim_in  [2];
  logic signed [COORD_W-1:0] pos_out [2];
  logic signed [COORD_W-1:0] len_out [2];

  assign pos_in[0] = rd_data[4*COORD_W-1 -: COORD_W];
  assign pos_in[1] = rd_data[3*COORD_W-1 -: COORD_W];
  assign len_in[0] = rd_data[2*COORD_W-1 -: COORD_W];
  assign len_in[1] = rd_data[COORD_W-1:0];
  assign lim_in[0] = surf_w;
  assign lim_in[1] = surf_h;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    rfe_axis_clamp #(.COORD_W(COORD_W)) u_clamp (
      .pos_i(pos_in[a]),
      .len_i(len_in[a]),
      .lim_i(lim_in[a]),
      .pos_o(pos_out[a]),
      .len_o(len_out[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q       <= '0;
      rd_q       <= '0;
      drain_q    <= 1'b0;
      s1_v       <= 1'b0;
      rect_valid <= 1'b0;
      rect_x     <= '0;
      rect_y     <= '0;
      rect_w     <= '0;
      rect_h     <= '0;
    end else begin
      if (push) wr_q <= wr_q + DQ_AW'(1);
      s1_v <= pop;
      if (wipe) begin
        rd_q    <= push ? wr_q + DQ_AW'(1) : wr_q;
        drain_q <= 1'b0;
      end else begin
        if (pop) rd_q <= rd_q + DQ_AW'(1);
        if (flush_req) drain_q <= 1'b1;
        else if (drain_q && rd_q == wr_q) drain_q <= 1'b0;
      end
      rect_valid <= s1_v;
      rect_x     <= pos_out[0];
      rect_y     <= pos_out[1];
      rect_w     <= len_out[0];
      rect_h     <= len_out[1];
    end
  end

  // R8: a discarding flush leaves no pending entries
  a_r8_wipe_empties: assert property (@(posedge clk) disable iff (rst)
    (wipe && !push) |=> (rd_q == wr_q));
  // R10 / R11: emitted rectangles are never negative
  a_r10_nonneg: assert property (@(posedge clk) disable iff (rst)
    rect_valid |-> (!rect_x[COORD_W-1] && !rect_w[COORD_W-1] &&
                    !rect_y[COORD_W-1] && !rect_h[COORD_W-1]));
  // R10: emitted rectangle fits the surface width
  a_r10_fits_width: assert property (@(posedge clk) disable iff (rst)
    rect_valid |-> (({1'b0, rect_x} + {1'b0, rect_w}) <= {1'b0, $past(surf_w)}));
  // R11: emitted rectangle fits the surface height
  a_r11_fits_height: assert property (@(posedge clk) disable iff (rst)
    rect_valid |-> (({1'b0, rect_y} + {1'b0, rect_h}) <= {1'b0, $past(surf_h)}));
endmodule

// File: rtl/rect_fill_copy_engine.sv
module rect_fill_copy_engine #(
  parameter int ADDR_W  = 20,
  parameter int COORD_W = 12,
  parameter int PITCH_W = 12,
  parameter int DQ_AW   = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PITCH_W-1:0]        cfg_pitch,
  input  logic [2:0]                cfg_bpp,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic                      cmd_op,
  input  logic [31:0]               cmd_color,
  input  logic signed [COORD_W-1:0] cmd_sx,
  input  logic signed [COORD_W-1:0] cmd_sy,
  input  logic signed [COORD_W-1:0] cmd_dx,
  input  logic signed [COORD_W-1:0] cmd_dy,
  input  logic signed [COORD_W-1:0] cmd_w,
  input  logic signed [COORD_W-1:0] cmd_h,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_we,
  output logic                      mem_re,
  output logic [7:0]                mem_wdata,
  input  logic [7:0]                mem_rdata,
  input  logic [COORD_W-1:0]        surf_w,
  input  logic [COORD_W-1:0]        surf_h,
  input  logic                      flush_req,
  input  logic                      invalidate,
  output logic                      rect_valid,
  output logic signed [COORD_W-1:0] rect_x,
  output logic signed [COORD_W-1:0] rect_y,
  output logic signed [COORD_W-1:0] rect_w,
  output logic signed [COORD_W-1:0] rect_h
);
  logic                      push;
  logic signed [COORD_W-1:0] push_x, push_y, push_w, push_h;

  rfe_engine #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .PITCH_W(PITCH_W)) u_engine (
    .clk(clk), .rst(rst),
    .cfg_pitch(cfg_pitch), .cfg_bpp(cfg_bpp),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_color(cmd_color),
    .cmd_sx(cmd_sx), .cmd_sy(cmd_sy), .cmd_dx(cmd_dx), .cmd_dy(cmd_dy),
    .cmd_w(cmd_w), .cmd_h(cmd_h),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .push(push), .push_x(push_x), .push_y(push_y), .push_w(push_w), .push_h(push_h)
  );

  rfe_dirty_ring #(.COORD_W(COORD_W), .DQ_AW(DQ_AW)) u_ring (
    .clk(clk), .rst(rst),
    .push(push), .push_x(push_x), .push_y(push_y), .push_w(push_w), .push_h(push_h),
    .flush_req(flush_req), .invalidate(invalidate),
    .surf_w(surf_w), .surf_h(surf_h),
    .rect_valid(rect_valid), .rect_x(rect_x), .rect_y(rect_y),
    .rect_w(rect_w), .rect_h(rect_h)
  );
endmodule

// File: tb/sim_rect_fill_copy_engine.sv
module sim_rect_fill_copy_engine;
  localparam int AW = 12;
  localparam int CW = 12;
  localparam int MEMSZ = 1 << AW;
  localparam int PITCH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [11:0]          cfg_pitch;
  logic [2:0]           cfg_bpp;
  logic                 cmd_valid, cmd_ready, cmd_op;
  logic [31:0]          cmd_color;
  logic signed [CW-1:0] cmd_sx, cmd_sy, cmd_dx, cmd_dy, cmd_w, cmd_h;
  logic [AW-1:0]        mem_addr;
  logic                 mem_we, mem_re;
  logic [7:0]           mem_wdata, mem_rdata;
  logic [CW-1:0]        surf_w, surf_h;
  logic                 flush_req, invalidate;
  logic                 rect_valid;
  logic signed [CW-1:0] rect_x, rect_y, rect_w, rect_h;

  rect_fill_copy_engine #(.ADDR_W(AW), .COORD_W(CW), .PITCH_W(12), .DQ_AW(9)) u0 (
    .clk(clk), .rst(rst), .cfg_pitch(cfg_pitch), .cfg_bpp(cfg_bpp),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_color(cmd_color), .cmd_sx(cmd_sx), .cmd_sy(cmd_sy),
    .cmd_dx(cmd_dx), .cmd_dy(cmd_dy), .cmd_w(cmd_w), .cmd_h(cmd_h),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .surf_w(surf_w), .surf_h(surf_h), .flush_req(flush_req), .invalidate(invalidate),
    .rect_valid(rect_valid), .rect_x(rect_x), .rect_y(rect_y),
    .rect_w(rect_w), .rect_h(rect_h)
  );

  // framebuffer model: one byte per access, read data one cycle later
  logic [7:0] fb   [0:MEMSZ-1];
  logic [7:0] refm [0:MEMSZ-1];
  logic [7:0] tmp  [0:4095];
  always @(posedge clk) begin
    if (mem_we) fb[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= fb[mem_addr];
  end

  int n_chk = 0;
  int n_fail = 0;
  int wcnt = 0;
  int rcnt = 0;
  int got_n = 0;
  int got_x [0:63];
  int got_y [0:63];
  int got_w [0:63];
  int got_h [0:63];
  int exp_n = 0;
  int exp_x [0:63];
  int exp_y [0:63];
  int exp_w [0:63];
  int exp_h [0:63];
  int cyc = 0;

  always @(negedge clk) begin
    if (mem_we) wcnt++;
    if (mem_re) rcnt++;
    if (rect_valid && got_n < 64) begin
      got_x[got_n] = int'(rect_x);
      got_y[got_n] = int'(rect_y);
      got_w[got_n] = int'(rect_w);
      got_h[got_n] = int'(rect_h);
      got_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic clamp_axis(input int p, input int l, input int lim, output int po, output int lo);
    if (p < 0) begin l = l + p; p = 0; end
    if (l < 0) l = 0;
    if (p + l > lim) begin
      if (p > lim) p = lim;
      l = lim - p;
    end
    po = p;
    lo = l;
  endtask

  task automatic push_exp(input int x, input int y, input int w, input int h);
    int cx, cy, cwd, ch;
    clamp_axis(x, w, int'(surf_w), cx, cwd);
    clamp_axis(y, h, int'(surf_h), cy, ch);
    exp_x[exp_n] = cx;
    exp_y[exp_n] = cy;
    exp_w[exp_n] = cwd;
    exp_h[exp_n] = ch;
    exp_n++;
  endtask

  task automatic apply_ref(input bit op, input logic [31:0] col, input int sx, input int sy,
                           input int dx, input int dy, input int w, input int h, input int bpp);
    if (w <= 0 || h <= 0) return;
    if (!op) begin
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++)
          for (int b = 0; b < bpp; b++)
            refm[bpp*(dx+c) + PITCH*(dy+r) + b] = col[8*b +: 8];
    end else begin
      for (int r = 0; r < h; r++)
        for (int k = 0; k < w*bpp; k++)
          tmp[r*64 + k] = refm[bpp*sx + PITCH*(sy+r) + k];
      for (int r = 0; r < h; r++)
        for (int k = 0; k < w*bpp; k++)
          refm[bpp*dx + PITCH*(dy+r) + k] = tmp[r*64 + k];
    end
  endtask

  // called just after a falling edge
  task automatic run_cmd(input bit op, input logic [31:0] col, input int sx, input int sy,
                         input int dx, input int dy, input int w, input int h, input int bpp,
                         input string req, input bit chk);
    int w0, r0, bad, ew, er, nbytes;
    w0 = wcnt;
    r0 = rcnt;
    cfg_bpp   = 3'(bpp);
    cmd_op    = op;
    cmd_color = col;
    cmd_sx = CW'(sx); cmd_sy = CW'(sy); cmd_dx = CW'(dx); cmd_dy = CW'(dy);
    cmd_w  = CW'(w);  cmd_h  = CW'(h);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (chk) check(cmd_ready == 1'b0, "R6 ready low after accept", int'(cmd_ready), 0);
    while (!cmd_ready) @(negedge clk);
    if (!chk) return;
    apply_ref(op, col, sx, sy, dx, dy, w, h, bpp);
    bad = 0;
    for (int i = 0; i < MEMSZ; i++) if (fb[i] !== refm[i]) bad++;
    check(bad == 0, {req, " framebuffer bytes"}, bad, 0);
    nbytes = (w > 0 && h > 0) ? w*h*bpp : 0;
    ew = nbytes;
    er = (nbytes == 0) ? 0 : (op ? nbytes : (h-1)*w*bpp);
    check((wcnt - w0) == ew && (rcnt - r0) == er, {req, " access count (writes)"}, wcnt - w0, ew);
  endtask

  task automatic do_flush(input bit inv, input string req);
    got_n = 0;
    flush_req  = 1'b1;
    invalidate = inv;
    @(negedge clk);
    flush_req  = 1'b0;
    invalidate = 1'b0;
    if (!inv && exp_n > 0) begin
      @(negedge clk);
      check(rect_valid == 1'b0, "R9 no output one edge after flush", int'(rect_valid), 0);
      @(negedge clk);
      check(rect_valid == 1'b1, "R9 first output two edges after flush", int'(rect_valid), 1);
    end
    repeat (80) @(negedge clk);
    if (inv) begin
      check(got_n == 0, "R8 discard emits nothing", got_n, 0);
    end else begin
      check(got_n == exp_n, {req, " rectangle count"}, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
        check(got_x[i] == exp_x[i], {req, " x"}, got_x[i], exp_x[i]);
        check(got_y[i] == exp_y[i], {req, " y"}, got_y[i], exp_y[i]);
        check(got_w[i] == exp_w[i], {req, " w"}, got_w[i], exp_w[i]);
        check(got_h[i] == exp_h[i], {req, " h"}, got_h[i], exp_h[i]);
      end
    end
  endtask

  initial begin
    cfg_pitch = 12'(PITCH);
    cfg_bpp = 3'd1;
    cmd_valid = 1'b0; cmd_op = 1'b0; cmd_color = '0;
    cmd_sx = '0; cmd_sy = '0; cmd_dx = '0; cmd_dy = '0; cmd_w = '0; cmd_h = '0;
    surf_w = 12'd40; surf_h = 12'd30;
    flush_req = 1'b0; invalidate = 1'b0;
    for (int i = 0; i < MEMSZ; i++) begin
      fb[i]   = 8'((i * 7 + 3) & 255);
      refm[i] = 8'((i * 7 + 3) & 255);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check(cmd_ready == 1'b1, "R6 ready after reset", int'(cmd_ready), 1);
    check(rect_valid == 1'b0, "R9 no rectangle after reset", int'(rect_valid), 0);
    check(mem_we == 1'b0 && mem_re == 1'b0, "R6 idle memory after reset", int'(mem_we), 0);

    // R1 R2 fills, R3 R4 copies, every pixel size
    for (int bpp = 1; bpp <= 4; bpp++) begin
      run_cmd(1'b0, 32'hA1B2C3D4 + 32'(bpp), 0, 0, bpp, 2*bpp, 3, 3, bpp, "R1 R2 fill", 1'b1);
      push_exp(bpp, 2*bpp, 3, 3);
      run_cmd(1'b1, 0, 2, 4, 3, 6, 4, 4, bpp, "R3 copy down overlap", 1'b1);
      push_exp(3, 6, 4, 4);
      run_cmd(1'b1, 0, 2, 8, 1, 6, 4, 4, bpp, "R3 copy up overlap", 1'b1);
      push_exp(1, 6, 4, 4);
      run_cmd(1'b1, 0, 1, 12, 3, 12, 5, 2, bpp, "R4 row shift right", 1'b1);
      push_exp(3, 12, 5, 2);
      run_cmd(1'b1, 0, 4, 14, 2, 14, 5, 2, bpp, "R4 row shift left", 1'b1);
      push_exp(2, 14, 5, 2);
    end
    do_flush(1'b0, "R7 R9 drained rectangles");

    // R5 zero-size commands carry clamp cases for R10 and R11
    exp_n = 0;
    run_cmd(1'b0, 32'h11, 0, 0, -3, 5, 10, 0, 2, "R5 R10 negative x", 1'b1);
    push_exp(-3, 5, 10, 0);
    run_cmd(1'b0, 32'h22, 0, 0, 30, 2, 20, 0, 1, "R5 R10 trim width", 1'b1);
    push_exp(30, 2, 20, 0);
    run_cmd(1'b1, 32'h0, 0, 0, 45, 1, 5, 0, 3, "R5 R10 x beyond surface", 1'b1);
    push_exp(45, 1, 5, 0);
    run_cmd(1'b0, 32'h33, 0, 0, -8, 0, 5, 0, 1, "R5 R10 negative width", 1'b1);
    push_exp(-8, 0, 5, 0);
    run_cmd(1'b0, 32'h44, 0, 0, 2, -2, 0, 6, 4, "R5 R11 negative y", 1'b1);
    push_exp(2, -2, 0, 6);
    run_cmd(1'b1, 32'h0, 0, 0, 2, 25, 0, 9, 2, "R5 R11 trim height", 1'b1);
    push_exp(2, 25, 0, 9);
    run_cmd(1'b0, 32'h55, 0, 0, 3, 40, -2, 4, 1, "R5 R11 y beyond surface", 1'b1);
    push_exp(3, 40, -2, 4);
    do_flush(1'b0, "R10 R11 clamped rectangles");

    // R8 discard
    exp_n = 0;
    for (int i = 0; i < 3; i++)
      run_cmd(1'b0, 0, 0, 0, i, i, 0, 0, 1, "R8 setup", 1'b1);
    do_flush(1'b1, "R8 discard");
    do_flush(1'b0, "R8 nothing left after discard");

    // R7 modulo-512 wrap of the ring
    surf_w = 12'd1000;
    exp_n = 0;
    for (int i = 0; i < 515; i++)
      run_cmd(1'b0, 0, 0, 0, 0, 0, i, 0, 1, "R7 wrap", 1'b0);
    for (int i = 512; i < 515; i++) push_exp(0, 0, i, 0);
    do_flush(1'b0, "R7 wrapped ring");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule